// File: doc/BRIEF.md
# Banked Paging Memory Management Unit

This block sits between an 8-bit processor with a 16-bit address bus and a 512 KB RAM. It turns every logical address into a 19-bit physical address. The logical space is cut into eight 8 KB windows. Address bits [15:13] pick a window, and each window owns a 6-bit page register that names one of 64 physical 8 KB pages. Two complete sets of eight page registers exist. A single task bit picks which set is live, so an operating system can swap the whole memory map in one write.

Two regions near the top of the space do not follow the window mapping. The 256-byte page at 0xFE00 can be pinned to a fixed physical page for interrupt vectors. Everything from 0xFF00 upward belongs to hardware ports: the block raises an I/O select there instead of a RAM select. The page registers and a control byte live inside that port region. The processor writes and reads them back with ordinary bus cycles.

Translation is combinational, so the physical address is ready in the same cycle as the logical one. Register writes take effect at the next rising clock edge.

Top module: `bank_mmu`

## Requirements
- R1: For every RAM access, physical bits [12:0] equal logical bits [12:0], and logical bits [15:13] choose the window.
- R2: Below 0xFE00 the physical bits [18:13] equal the page register of the live task set for the window; ram_sel is 1 and io_sel is 0.
- R3: A write (cpu_we high) to 0xFFA0–0xFFAF stores cpu_wdata[5:0] in one page register. Address bit 3 selects the task set (0 or 1) and bits [2:0] select the window. The new value is used from the next clock edge on, and no other register changes.
- R4: A write to 0xFF91 loads the task select from data bit 0 and the vector enable from data bit 3. The other data bits are ignored.
- R5: With the vector enable at 1, addresses 0xFE00–0xFEFF map to physical page 0x3F with the offset kept, whatever window 7 holds.
- R6: With the vector enable at 0, addresses 0xFE00–0xFEFF translate through window 7 of the live task set like any RAM address.
- R7: Addresses 0xFF00–0xFFFF give io_sel = 1, ram_sel = 0 and phys_addr = 0.
- R8: Read data returns {2'b00, register} at 0xFFA0–0xFFAF (same index rule as R3). It returns {4'b0, vector enable, 2'b00, task select} at 0xFF91, and 0 at every other address.
- R9: After reset all sixteen page registers, the task select and the vector enable are 0, so every address below 0xFF00 maps to page 0.
- R10: With cpu_we low no state changes. Writes to port addresses other than 0xFF91 and 0xFFA0–0xFFAF, and writes to RAM addresses, leave the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | Logical address from the processor |
| cpu_wdata | input | 8 | Write data from the processor |
| cpu_we | input | 1 | Write strobe, sampled on the rising edge |
| phys_addr | output | 19 | Translated physical RAM address |
| ram_sel | output | 1 | Access goes to RAM |
| io_sel | output | 1 | Access goes to the port region |
| rdata | output | 8 | Read-back of the page registers and the control byte |

## Verification
The checker assumes that the address is held steady by the processor for a whole cycle and changes only between clock edges. It also assumes that cpu_we is a clean level that is known at every rising edge. The stability property relies on this: an unchanged address with no write must give an unchanged physical address. The bench drives all inputs at the falling edge and always drives every input. It keeps the write strobe low on every cycle that only checks, so no register changes except through the writes it models.

// File: rtl/bank_mmu_pkg.sv
package bank_mmu_pkg;
  // Port-region decode (upper address byte)
  localparam logic [7:0]  IO_HI       = 8'hFF;
  localparam logic [7:0]  VEC_HI      = 8'hFE;
  // Page register block base (16 aligned bytes) and control byte
  localparam logic [15:0] MAP_BASE    = 16'hFFA0;
  localparam logic [15:0] CTRL_ADDR   = 16'hFF91;
  // Control byte field positions
  localparam int          CTRL_TASK_BIT = 0;
  localparam int          CTRL_VEC_BIT  = 3;

  typedef struct packed {
    logic vec_en;
    logic task_sel;
  } mmu_ctrl_t;
endpackage

// File: rtl/bank_mmu_rst_sync.sv
module bank_mmu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bank_mmu_pagefile.sv
module bank_mmu_pagefile #(
  parameter int PAGE_W = 6,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  xl_idx,
  input  logic [IDX_W-1:0]  bus_idx,
  output logic [PAGE_W-1:0] xl_page,
  output logic [PAGE_W-1:0] bus_page
);
  localparam int NREG = 1 << IDX_W;

  logic [NREG-1:0][PAGE_W-1:0] page_q;
  logic [NREG-1:0][PAGE_W-1:0] page_d;
  logic [NREG-1:0]             reg_ce;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_comb begin
      reg_ce[i] = wr_en && (wr_idx == IDX_W'(i));
      page_d[i] = reg_ce[i] ? wr_data : page_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) page_q[i] <= '0;
      else        page_q[i] <= page_d[i];
    end
  end

  assign xl_page  = page_q[xl_idx];
  assign bus_page = page_q[bus_idx];
endmodule

// File: rtl/bank_mmu_ctrl.sv
module bank_mmu_ctrl
  import bank_mmu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output mmu_ctrl_t         ctrl
);
  mmu_ctrl_t ctrl_q, ctrl_d;
  logic      unused_ctrl_bits;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.task_sel = wr_data[CTRL_TASK_BIT];
      ctrl_d.vec_en   = wr_data[CTRL_VEC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign unused_ctrl_bits = ^wr_data;
  assign ctrl = ctrl_q;
endmodule

// File: rtl/bank_mmu_xlate.sv
module bank_mmu_xlate
  import bank_mmu_pkg::*;
#(
  parameter int          PAGE_W   = 6,
  parameter int          WIN_W    = 3,
  parameter int          OFF_W    = 13,
  parameter logic [5:0]  VEC_PAGE = 6'h3F,
  localparam int         ADDR_W   = WIN_W + OFF_W,
  localparam int         PHYS_W   = PAGE_W + OFF_W,
  localparam int         IDX_W    = WIN_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  mmu_ctrl_t         ctrl,
  input  logic [PAGE_W-1:0] xl_page,
  output logic [IDX_W-1:0]  xl_idx,
  output logic [PHYS_W-1:0] phys,
  output logic              ram_sel,
  output logic              io_sel,
  output logic              map_hit,
  output logic              ctrl_hit
);
  logic in_io, in_vec;

  always_comb begin
    in_io    = addr[ADDR_W-1 -: 8] == IO_HI;
    in_vec   = addr[ADDR_W-1 -: 8] == VEC_HI;
    map_hit  = addr[ADDR_W-1:IDX_W] == MAP_BASE[ADDR_W-1:IDX_W];
    ctrl_hit = addr == CTRL_ADDR;
    xl_idx   = {ctrl.task_sel, addr[ADDR_W-1 -: WIN_W]};
    io_sel   = in_io;
    ram_sel  = !in_io;
    if (in_io)
      phys = '0;
    else if (in_vec && ctrl.vec_en)
      phys = {VEC_PAGE[PAGE_W-1:0], addr[OFF_W-1:0]};
    else
      phys = {xl_page, addr[OFF_W-1:0]};
  end
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
  import bank_mmu_pkg::*;
#(
  parameter int         PAGE_W   = 6,
  parameter int         WIN_W    = 3,
  parameter int         OFF_W    = 13,
  parameter int         DATA_W   = 8,
  parameter logic [5:0] VEC_PAGE = 6'h3F,
  localparam int        ADDR_W   = WIN_W + OFF_W,
  localparam int        PHYS_W   = PAGE_W + OFF_W,
  localparam int        IDX_W    = WIN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              ram_sel,
  output logic              io_sel,
  output logic [DATA_W-1:0] rdata
);
  logic              rst_sync_n;
  mmu_ctrl_t         ctrl;
  logic [IDX_W-1:0]  xl_idx;
  logic [PAGE_W-1:0] xl_page, bus_page;
  logic              map_hit, ctrl_hit;
  logic              map_we, ctrl_we;
  logic              vec_en_w, task_sel_w;

  bank_mmu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bank_mmu_xlate #(
    .PAGE_W(PAGE_W), .WIN_W(WIN_W), .OFF_W(OFF_W), .VEC_PAGE(VEC_PAGE)
  ) u_xlate (
    .addr     (cpu_addr),
    .ctrl     (ctrl),
    .xl_page  (xl_page),
    .xl_idx   (xl_idx),
    .phys     (phys_addr),
    .ram_sel  (ram_sel),
    .io_sel   (io_sel),
    .map_hit  (map_hit),
    .ctrl_hit (ctrl_hit)
  );

  assign map_we  = cpu_we && map_hit;
  assign ctrl_we = cpu_we && ctrl_hit;

  bank_mmu_pagefile #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_pages (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (map_we),
    .wr_idx   (cpu_addr[IDX_W-1:0]),
    .wr_data  (cpu_wdata[PAGE_W-1:0]),
    .xl_idx   (xl_idx),
    .bus_idx  (cpu_addr[IDX_W-1:0]),
    .xl_page  (xl_page),
    .bus_page (bus_page)
  );

  bank_mmu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (ctrl_we),
    .wr_data (cpu_wdata),
    .ctrl    (ctrl)
  );

  assign vec_en_w   = ctrl.vec_en;
  assign task_sel_w = ctrl.task_sel;

  always_comb begin
    rdata = '0;
    if (map_hit) begin
      rdata[PAGE_W-1:0] = bus_page;
    end else if (ctrl_hit) begin
      rdata[CTRL_TASK_BIT] = task_sel_w;
      rdata[CTRL_VEC_BIT]  = vec_en_w;
    end
  end
endmodule

// File: rtl/bank_mmu_chk.sv
module bank_mmu_chk #(
  parameter int         PAGE_W   = 6,
  parameter int         OFF_W    = 13,
  parameter int         DATA_W   = 8,
  parameter logic [5:0] VEC_PAGE = 6'h3F
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [15:0]             cpu_addr,
  input logic                    cpu_we,
  input logic [PAGE_W+OFF_W-1:0] phys_addr,
  input logic                    ram_sel,
  input logic                    io_sel,
  input logic [DATA_W-1:0]       rdata,
  input logic                    vec_en
);
  // R1: offset passes through on RAM accesses
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

  // R7: port region selects I/O only
  assert_io_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:8] == 8'hFF) |-> (io_sel && !ram_sel && phys_addr == '0));

  // R2/R7: exactly one select at a time
  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_sel, io_sel}) == 1);

  // R5: pinned vector page
  assert_vector_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_en && cpu_addr[15:8] == 8'hFE) |-> phys_addr[PAGE_W+OFF_W-1:OFF_W] == VEC_PAGE[PAGE_W-1:0]);

  // R10: no write means the mapping of a held address does not move
  assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> (!$stable(cpu_addr) || $stable(phys_addr)));

  // R8: page register read-back has zero upper bits
  assert_readback_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:4] == 12'hFFA) |-> rdata[DATA_W-1:PAGE_W] == '0);
endmodule

bind bank_mmu bank_mmu_chk #(
  .PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .VEC_PAGE(VEC_PAGE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_we    (cpu_we),
  .phys_addr (phys_addr),
  .ram_sel   (ram_sel),
  .io_sel    (io_sel),
  .rdata     (rdata),
  .vec_en    (vec_en_w)
);

// File: tb/bank_mmu_tb.sv
`timescale 1ns/100ps
module bank_mmu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [18:0] phys_addr;
  logic        ram_sel, io_sel;
  logic [7:0]  rdata;

  always #2.5 clk = ~clk;

  bank_mmu u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .phys_addr(phys_addr), .ram_sel(ram_sel),
    .io_sel(io_sel), .rdata(rdata)
  );

  typedef struct {
    logic [15:0] addr;
    logic [18:0] phys;
    logic        ram;
    logic        io;
    logic [7:0]  rd;
    string       tag;
  } item_t;

  item_t     sb_q[$];
  int        vectors = 0;
  int        fails = 0;
  bit        done = 0;
  logic [5:0] mdl [2][8];
  logic       m_task, m_vec;

  task automatic model_reset();
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 8; w++) mdl[t][w] = '0;
    m_task = 0; m_vec = 0;
  endtask

  // Write cycle; model follows R3/R4/R10
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    if (a[15:4] == 12'hFFA) mdl[a[3]][a[2:0]] = d[5:0];
    else if (a == 16'hFF91) begin m_task = d[0]; m_vec = d[3]; end
  endtask

  // Drive with strobe low, no model change (R10)
  task automatic idle(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b0;
  endtask

  task automatic chk(input logic [15:0] a, input string tag);
    item_t it;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = 8'hA5; cpu_we = 1'b0;
    it.addr = a; it.tag = tag;
    it.io  = (a[15:8] == 8'hFF);
    it.ram = !it.io;
    if (it.io) it.phys = '0;
    else if (a[15:8] == 8'hFE && m_vec) it.phys = {6'h3F, a[12:0]};
    else it.phys = {mdl[m_task][a[15:13]], a[12:0]};
    if (a[15:4] == 12'hFFA) it.rd = {2'b00, mdl[a[3]][a[2:0]]};
    else if (a == 16'hFF91) it.rd = {4'b0, m_vec, 2'b00, m_task};
    else it.rd = 8'h00;
    sb_q.push_back(it);
  endtask

  // Monitor: sample just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        vectors++;
        if (phys_addr !== it.phys || ram_sel !== it.ram || io_sel !== it.io || rdata !== it.rd) begin
          fails++;
          $display("FAIL %s addr=%h: phys=%h ram=%b io=%b rd=%h expected phys=%h ram=%b io=%b rd=%h",
                   it.tag, it.addr, phys_addr, ram_sel, io_sel, rdata,
                   it.phys, it.ram, it.io, it.rd);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state
    chk(16'h0000, "R9");
    chk(16'h5678, "R9");
    chk(16'hE123, "R9");
    chk(16'hFE10, "R9");
    chk(16'hFF91, "R9");
    chk(16'hFFAF, "R9");

    // R3: load both sets, upper data bits set to prove masking
    for (int w = 0; w < 8; w++) wr(16'hFFA0 + 16'(w), 8'hC0 | 8'(8 + w));
    for (int w = 0; w < 8; w++) wr(16'hFFA8 + 16'(w), 8'h40 | 8'(8'h20 + w));

    // R1/R2/R3: task set 0 each window
    for (int w = 0; w < 8; w++) chk(16'(w * 16'h2000) + 16'h0ABC, "R2");
    chk(16'h1FFF, "R1");
    chk(16'hFDFF, "R2");
    // R8: read-back of all sixteen
    for (int i = 0; i < 16; i++) chk(16'hFFA0 + 16'(i), "R8");
    chk(16'hFF92, "R8");
    // R6: vector page off, window 7
    chk(16'hFE40, "R6");

    // R4: switch to task set 1
    wr(16'hFF91, 8'h01);
    chk(16'hFF91, "R4");
    for (int w = 0; w < 8; w++) chk(16'(w * 16'h2000) + 16'h1357, "R4");
    chk(16'hFE40, "R6");

    // R4/R5: other bits ignored, vector on
    wr(16'hFF91, 8'hF9);
    chk(16'hFF91, "R4");
    chk(16'hFE00, "R5");
    chk(16'hFEFF, "R5");
    chk(16'hFDFF, "R5");
    wr(16'hFF91, 8'h08);
    chk(16'hFE7E, "R5");
    chk(16'hE000, "R2");

    // R7: port region
    chk(16'hFF00, "R7");
    chk(16'hFFFF, "R7");
    chk(16'hFFA3, "R7");

    // R3: single register update takes effect next edge
    wr(16'hFFA5, 8'h3F);
    chk(16'hA000, "R3");
    chk(16'hFFA4, "R3");
    chk(16'hFFA6, "R3");

    // R10: strobe low, other ports, RAM writes
    idle(16'hFFA5, 8'h11);
    chk(16'hFFA5, "R10");
    idle(16'hFF91, 8'h01);
    chk(16'hFF91, "R10");
    wr(16'hFF92, 8'h01);
    wr(16'hFF90, 8'h09);
    wr(16'h4000, 8'h15);
    wr(16'hFEA5, 8'h15);
    chk(16'hFF91, "R10");
    chk(16'hA000, "R10");
    chk(16'h4000, "R10");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule